// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase-shifted outputs of an incremental rotary or linear encoder into a relative position count. Both phase inputs are brought into the clock domain through a chain of flops, and the block compares each synchronized sample with the one before it to find transitions. A 2-bit mode input chooses which transitions advance the count: only those of channel 2, only those of channel 1, or those of both channels. In each case the level of the other channel gives the direction.

The count runs between zero and a programmable wrap limit. Counting up past the limit returns it to zero, and counting down past zero loads the limit. Each wrap raises a single-cycle pulse, which a host can use to extend the position into a wider word. If both channels change in the same sampled cycle, the direction of that transition cannot be known. The count then stays where it is and an error pulse is raised. The direction output keeps the sense of the last valid step, so it shows which way the shaft was last moving.

Top module: `qenc_pos_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0, dir_o is 0, and ovf_o, unf_o and err_o are 0.
- R2: With mode_i = 2'b01, only channel 2 transitions count. The count goes up when the new ch2 level equals the ch1 level, and down otherwise.
- R3: With mode_i = 2'b10, only channel 1 transitions count. The count goes up when the new ch1 level differs from the ch2 level, and down otherwise.
- R4: With mode_i = 2'b11, transitions of both channels count under the rules of R2 and R3. A full quadrature cycle (ch1,ch2 = 00,10,11,01,00) therefore adds four, and the reverse order subtracts four.
- R5: With mode_i = 2'b00, count_o holds and ovf_o, unf_o and err_o stay 0, whatever the inputs do.
- R6: An up step from a count greater than or equal to reload_i gives 0, with ovf_o high for exactly that one cycle.
- R7: A down step from 0 loads reload_i, with unf_o high for exactly that one cycle.
- R8: When mode_i is nonzero and both synchronized channels change in the same cycle, the count is unchanged and err_o is high for one cycle.
- R9: dir_o is 1 after an up step and 0 after a down step. It holds its value through cycles with no valid step.
- R10: Each input passes through two synchronizing flops. A level change seen at rising edge k affects count_o from rising edge k+2, and mode_i and reload_i act on the edge at which the step is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Decode mode: 00 hold, 01 ch2 edges, 10 ch1 edges, 11 both |
| ch1_i | input | 1 | Encoder phase channel 1, asynchronous |
| ch2_i | input | 1 | Encoder phase channel 2, asynchronous |
| reload_i | input | CNT_W | Wrap limit, the highest count value |
| count_o | output | CNT_W | Relative position |
| dir_o | output | 1 | Direction of the last valid step, 1 means up |
| ovf_o | output | 1 | One-cycle pulse when the count wraps from the limit to zero |
| unf_o | output | 1 | One-cycle pulse when the count wraps from zero to the limit |
| err_o | output | 1 | One-cycle pulse for a transition in which both channels changed |

## Verification
A wrong previous-sample register or a wrong direction rule shows up at count_o in the cycle the step is taken, two edges after the input is sampled. From then on, every later value of count_o is offset by that error. A wrong wrap comparison is seen as a missing or extra ovf_o/unf_o pulse, or as a wrong value after a wrap. A faulty invalid-transition path shows as a count that moves while err_o is high. The bench steps a behavioural model on every clock and compares all five outputs each cycle, so any of these faults is caught in the first cycle it appears.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_CH2  = 2'b01,
    MODE_CH1  = 2'b10,
    MODE_BOTH = 2'b11
  } qenc_mode_e;

  typedef struct packed {
    logic inc;
    logic dec;
    logic err;
  } qenc_step_t;

  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  qenc_mode_e        mode_i,
  input  logic [NUM_CH-1:0] lvl_i,   // [0] ch1, [1] ch2
  output qenc_step_t        step_o
);
  logic [NUM_CH-1:0] prev_q;
  logic edge_1, edge_2, use_1, use_2, up_1, up_2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign edge_1 = lvl_i[0] ^ prev_q[0];
  assign edge_2 = lvl_i[1] ^ prev_q[1];
  assign use_1  = (mode_i == MODE_CH1) || (mode_i == MODE_BOTH);
  assign use_2  = (mode_i == MODE_CH2) || (mode_i == MODE_BOTH);
  // channel 1 step is up when levels differ; channel 2 has the opposite sign
  assign up_1   = lvl_i[0] ^ lvl_i[1];
  assign up_2   = ~(lvl_i[0] ^ lvl_i[1]);

  always_comb begin
    step_o = '0;
    if (mode_i != MODE_HOLD) begin
      if (edge_1 && edge_2) begin
        step_o.err = 1'b1;
      end else if (edge_1 && use_1) begin
        step_o.inc = up_1;
        step_o.dec = ~up_1;
      end else if (edge_2 && use_2) begin
        step_o.inc = up_2;
        step_o.dec = ~up_2;
      end
    end
  end
endmodule

// File: rtl/qenc_wrap_cnt.sv
module qenc_wrap_cnt
  import qenc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  qenc_step_t       step_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_top, at_zero;
  assign at_top  = count_o >= reload_i;
  assign at_zero = count_o == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      dir_o   <= 1'b0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      err_o <= step_i.err;
      if (step_i.inc) begin
        dir_o <= 1'b1;
        if (at_top) begin
          count_o <= '0;
          ovf_o   <= 1'b1;
        end else begin
          count_o <= count_o + ONE;
        end
      end else if (step_i.dec) begin
        dir_o <= 1'b0;
        if (at_zero) begin
          count_o <= reload_i;
          unf_o   <= 1'b1;
        end else begin
          count_o <= count_o - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter
  import qenc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             ch1_i,
  input  logic             ch2_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             err_o
);
  logic [NUM_CH-1:0] lvl;
  qenc_step_t        step;

  qenc_sync #(.STAGES(SYNC_STAGES), .WIDTH(NUM_CH)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ch2_i, ch1_i}),
    .sync_o  (lvl)
  );

  qenc_decode u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (qenc_mode_e'(mode_i)),
    .lvl_i  (lvl),
    .step_o (step)
  );

  qenc_wrap_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .reload_i (reload_i),
    .count_o  (count_o),
    .dir_o    (dir_o),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o),
    .err_o    (err_o)
  );
endmodule

// File: rtl/qenc_pos_counter_chk.sv
module qenc_pos_counter_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic [CNT_W-1:0] reload_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_o,
  input logic             ovf_o,
  input logic             unf_o,
  input logic             err_o
);
  a_r6_ovf_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> count_o == '0);

  a_r7_unf_to_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> count_o == $past(reload_i));

  a_r6_r7_one_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));

  a_r8_err_holds_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(count_o) && !ovf_o && !unf_o);

  a_r5_hold_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i) == 2'b00 |-> $stable(count_o) && !ovf_o && !unf_o && !err_o);

  a_r9_dir_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(count_o) && !ovf_o && !unf_o) |-> $stable(dir_o));

  a_r4_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(count_o) && !ovf_o && !unf_o) |->
      (count_o == $past(count_o) + CNT_W'(1) && dir_o) ||
      (count_o == $past(count_o) - CNT_W'(1) && !dir_o));
endmodule

bind qenc_pos_counter qenc_pos_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .reload_i (reload_i),
  .count_o  (count_o),
  .dir_o    (dir_o),
  .ovf_o    (ovf_o),
  .unf_o    (unf_o),
  .err_o    (err_o)
);

// File: tb/qenc_pos_counter_tb_top.sv
`timescale 1ns/1ps
module qenc_pos_counter_tb_top;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic          ch1_i = 1'b0, ch2_i = 1'b0;
  logic [CW-1:0] reload_i = 16'd1000;
  logic [CW-1:0] count_o;
  logic          dir_o, ovf_o, unf_o, err_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";
  int phase = 0;

  always #10 clk_i = ~clk_i;

  qenc_pos_counter #(.CNT_W(CW)) dut_i (.*);

  // reference model: inputs seen at edge k act on the count at edge k+2
  int m_count; bit m_dir, m_ovf, m_unf, m_err;
  bit h1a, h1b, h2a, h2b, h3a, h3b;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_count = 0; m_dir = 0; m_ovf = 0; m_unf = 0; m_err = 0;
      {h1a, h1b, h2a, h2b, h3a, h3b} = '0;
    end else begin
      bit ea, eb, up, stp;
      ea = h2a ^ h3a; eb = h2b ^ h3b;
      m_ovf = 0; m_unf = 0; m_err = 0; stp = 0; up = 0;
      if (mode_i != 2'b00) begin
        if (ea && eb) m_err = 1;
        else if (ea && mode_i[1]) begin stp = 1; up = (h2a != h2b); end
        else if (eb && mode_i[0]) begin stp = 1; up = (h2b == h2a); end
      end
      if (stp) begin
        m_dir = up;
        if (up) begin
          if (m_count >= int'(reload_i)) begin m_count = 0; m_ovf = 1; end
          else m_count++;
        end else begin
          if (m_count == 0) begin m_count = int'(reload_i); m_unf = 1; end
          else m_count--;
        end
      end
      h3a = h2a; h3b = h2b; h2a = h1a; h2b = h1b; h1a = ch1_i; h1b = ch2_i;
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk_i) begin
    if (!done) begin
      chk("count_o", int'(count_o), m_count);
      chk("dir_o",   int'(dir_o),   int'(m_dir));
      chk("ovf_o",   int'(ovf_o),   int'(m_ovf));
      chk("unf_o",   int'(unf_o),   int'(m_unf));
      chk("err_o",   int'(err_o),   int'(m_err));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // forward order 00,10,11,01 as (ch1,ch2)
  task automatic set_phase(int p);
    int q;
    q = ((p % 4) + 4) % 4;
    ch1_i = (q == 1 || q == 2);
    ch2_i = (q == 2 || q == 3);
  endtask

  task automatic move(int steps, int gap);
    for (int i = 0; i < (steps < 0 ? -steps : steps); i++) begin
      @(negedge clk_i);
      phase += (steps < 0) ? -1 : 1;
      set_phase(phase);
      idle(gap);
    end
  endtask

  initial begin
    idle(3);
    cur_req = "R1";                      // reset state, compared each cycle
    chk("count_o reset", int'(count_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    idle(2);

    cur_req = "R4"; mode_i = 2'b11;      // R4: both edges, 4 per cycle
    move(8, 2);
    idle(4);
    chk("count_o after two cycles", int'(count_o), 8);
    move(-3, 1);
    idle(4);
    chk("count_o after reverse", int'(count_o), 5);

    cur_req = "R10"; move(1, 0);         // R10: back-to-back edges, min latency
    move(1, 0); move(-1, 0);
    idle(4);

    cur_req = "R2"; mode_i = 2'b01;      // R2: ch2 edges only
    move(6, 2); move(-5, 1);
    idle(3);

    cur_req = "R3"; mode_i = 2'b10;      // R3: ch1 edges only
    move(7, 2); move(-4, 2);
    idle(3);

    cur_req = "R9"; mode_i = 2'b01;      // R9: direction held across uncounted edges
    move(-1, 3);
    idle(3);

    cur_req = "R5"; mode_i = 2'b00;      // R5: hold mode ignores inputs
    move(9, 1); move(-6, 1);
    @(negedge clk_i); ch1_i = ~ch1_i; ch2_i = ~ch2_i;
    idle(4);
    phase = (ch1_i && !ch2_i) ? 1 : (ch1_i && ch2_i) ? 2 : (!ch1_i && ch2_i) ? 3 : 0;

    cur_req = "R6"; mode_i = 2'b11; reload_i = 16'd5;  // R6: up-wrap at limit
    move(12, 1);
    cur_req = "R7";                      // R7: down-wrap at zero
    move(-15, 1);
    cur_req = "R6"; reload_i = 16'd2;    // R6: count above a lowered limit wraps up
    idle(3);
    move(2, 2);
    cur_req = "R7"; reload_i = 16'd0;    // R7: zero limit
    move(-3, 2); move(2, 2);
    reload_i = 16'd300;

    cur_req = "R8";                      // R8: both channels flip together
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i); ch1_i = ~ch1_i; ch2_i = ~ch2_i;
      idle(3);
      move(2, 1);
    end
    mode_i = 2'b10;
    @(negedge clk_i); ch1_i = ~ch1_i; ch2_i = ~ch2_i;
    idle(4);

    cur_req = "R1";                      // R1: mid-run reset
    move(1, 0);
    @(negedge clk_i); rst_ni = 1'b0;
    idle(2);
    chk("count_o in reset", int'(count_o), 0);
    chk("dir_o in reset", int'(dir_o), 0);
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule